// File: doc/BRIEF.md
# Display power rail sequencer

This block holds an eight-bit panel control word and delivers it to an external serial-in, parallel-out latch over three wires: a serial clock, a data line and a strobe. Any change to the word is made in the block and then sent in full, so the latch always holds the word the block last sent. At reset the block loads a safe default word and sends it once without being asked.

On request it runs a timed power-up sequence that enables the negative panel rail and then the positive one. A power-down sequence removes them in the reverse order, with shorter waits. An all-off command clears every field at once, with no waits. A frame controller can also rewrite any single field of the word. Every wait is a whole number of microseconds, converted to system clock cycles by a parameter. The block executes one command at a time and holds one more command in a one-deep pending slot. A handshake reports whether each request started, was queued or was rejected, and when a command has finished.

Top module: `panel_rail_seq`

## Requirements
- R1: After reset the word is 0x32, with power disable, vertical start and scan direction set and all other fields clear. The block sends this word once on its own after reset. While reset is held, strobe, serial clock and source start are low and busy is high.
- R2: The word's bit positions are fixed: bit 0 latch enable, bit 1 power disable, bit 2 positive rail enable, bit 3 negative rail enable, bit 4 vertical start, bit 5 scan direction, bit 6 mode, bit 7 output enable. An update request with index i and value v writes v into bit i, leaves the other bits unchanged, and sends the word.
- R3: A send shifts the bits from bit 7 down to bit 0, eight bits in all. Each bit is placed on the data line while the serial clock is low and is taken by the latch on the rising clock edge. The strobe stays low for the whole send and rises after the eighth rising clock edge.
- R4: Power-up sends four words in turn. The first sets scan direction and clears power disable. The second sets the negative rail enable. The third sets the positive rail enable. The fourth sets vertical start.
- R5: During power-up, the time from one strobe rise to the next strobe fall is 100, 500 and 100 microseconds times CYC_PER_US, plus 2 cycles.
- R6: Power-down sends four words in turn. The first clears the positive rail enable. The second clears the negative rail enable. The third sets power disable. The fourth clears vertical start.
- R7: During power-down the same strobe gaps are 10 and 100 microseconds times CYC_PER_US, plus 2 cycles. The last two words are sent back to back with a gap of 2 cycles.
- R8: All-off clears all eight fields and sends the zero word as a single send.
- R9: Source start goes high in the cycle in which power-up finishes. It goes low when power-down or all-off finishes.
- R10: Busy is high from the cycle after a command is taken until the cycle in which done pulses. Done pulses once for one cycle when each command (the reset send included) ends.
- R11: A request that arrives while a command runs and the pending slot is empty is queued. Queued pulses for one cycle, and the command runs after the current one ends.
- R12: A request is rejected, and reject pulses for one cycle, in two cases: the pending slot is already full, or the request loses to another request in the same cycle. Priority is all-off, then power-off, then power-on, then update. A rejected request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| on_req | input | 1 | Power-up request pulse |
| off_req | input | 1 | Power-down request pulse |
| alloff_req | input | 1 | Immediate all-off request pulse |
| upd_req | input | 1 | Single-field update request pulse |
| upd_idx | input | 3 | Bit position of the field to write |
| upd_val | input | 1 | Value written to that field |
| ser_clk_o | output | 1 | Serial clock to the external latch |
| ser_dat_o | output | 1 | Serial data to the external latch |
| ser_str_o | output | 1 | Strobe; rising edge latches the word |
| src_start_o | output | 1 | Source start level |
| busy_o | output | 1 | A command is executing |
| done_o | output | 1 | One-cycle pulse when a command ends |
| queued_o | output | 1 | One-cycle pulse: request placed in the pending slot |
| reject_o | output | 1 | One-cycle pulse: a request was dropped |

## Verification
A request is sampled at a rising edge. Queued or reject appears one cycle later, and the strobe falls two cycles later, so the bench reads the handshake at the falling edge that follows the request cycle. Each send lasts 16*HALF_BIT cycles. A wait of D cycles places the next strobe fall exactly D+2 cycles after the previous strobe rise; done and source start change one cycle after the final strobe rise. The bench samples the serial lines at falling clock edges and rebuilds every latched word, keeping a cycle count at each strobe edge. It then compares the exact gaps with the values in R5 and R7.

// File: rtl/prs_pkg.sv
package prs_pkg;

    // Control word; first member is the most significant bit.
    typedef struct packed {
        logic out_en;    // bit 7
        logic mode;      // bit 6
        logic scan_dir;  // bit 5
        logic vstart;    // bit 4
        logic neg_en;    // bit 3
        logic pos_en;    // bit 2
        logic pwr_dis;   // bit 1
        logic latch;     // bit 0
    } panel_ctl_t;

    typedef enum logic [2:0] {
        CMD_INIT,
        CMD_ON,
        CMD_OFF,
        CMD_ALLOFF,
        CMD_UPD
    } cmd_e;

    typedef struct packed {
        cmd_e       cmd;
        logic [2:0] idx;
        logic       val;
    } req_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_SHIFT,
        ST_WAIT
    } seq_st_e;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH
    } sh_st_e;

    // Longest wait of any step, in microseconds.
    localparam int unsigned MAX_WAIT_US = 500;
    localparam int unsigned US_W        = $clog2(MAX_WAIT_US + 1);

    localparam panel_ctl_t CTL_RESET = '{
        out_en: 1'b0, mode: 1'b0, scan_dir: 1'b1, vstart: 1'b1,
        neg_en: 1'b0, pos_en: 1'b0, pwr_dis: 1'b1, latch: 1'b0
    };

    // One step of a command: the word to send, the wait after it,
    // whether it ends the command, and its effect on source start.
    typedef struct packed {
        panel_ctl_t       word;
        logic [US_W-1:0]  wait_us;
        logic             last;
        logic             src_hi;
        logic             src_lo;
    } step_t;

    function automatic step_t seq_step(cmd_e cmd, logic [1:0] step,
                                       panel_ctl_t cur, logic [2:0] idx,
                                       logic val);
        step_t      s;
        logic [7:0] w;
        s.word    = cur;
        s.wait_us = '0;
        s.last    = 1'b1;
        s.src_hi  = 1'b0;
        s.src_lo  = 1'b0;
        case (cmd)
            CMD_ON: begin
                case (step)
                    2'd0: begin
                        s.word.scan_dir = 1'b1;
                        s.word.pwr_dis  = 1'b0;
                        s.wait_us       = US_W'(100);
                        s.last          = 1'b0;
                    end
                    2'd1: begin
                        s.word.neg_en = 1'b1;
                        s.wait_us     = US_W'(500);
                        s.last        = 1'b0;
                    end
                    2'd2: begin
                        s.word.pos_en = 1'b1;
                        s.wait_us     = US_W'(100);
                        s.last        = 1'b0;
                    end
                    default: begin
                        s.word.vstart = 1'b1;
                        s.src_hi      = 1'b1;
                    end
                endcase
            end
            CMD_OFF: begin
                case (step)
                    2'd0: begin
                        s.word.pos_en = 1'b0;
                        s.wait_us     = US_W'(10);
                        s.last        = 1'b0;
                    end
                    2'd1: begin
                        s.word.neg_en = 1'b0;
                        s.wait_us     = US_W'(100);
                        s.last        = 1'b0;
                    end
                    2'd2: begin
                        s.word.pwr_dis = 1'b1;
                        s.last         = 1'b0;
                    end
                    default: begin
                        s.word.vstart = 1'b0;
                        s.src_lo      = 1'b1;
                    end
                endcase
            end
            CMD_ALLOFF: begin
                s.word   = '0;
                s.src_lo = 1'b1;
            end
            CMD_UPD: begin
                w      = cur;
                w[idx] = val;
                s.word = panel_ctl_t'(w);
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/prs_arbiter.sv
module prs_arbiter
    import prs_pkg::*;
(
    input  logic       on_req,
    input  logic       off_req,
    input  logic       alloff_req,
    input  logic       upd_req,
    input  logic [2:0] upd_idx,
    input  logic       upd_val,
    output logic       any,
    output logic       multi,
    output req_t       win
);
    logic [3:0] reqs;

    always_comb begin
        reqs  = {alloff_req, off_req, on_req, upd_req};
        any   = |reqs;
        multi = ($countones(reqs) > 1);
        win   = '{cmd: CMD_UPD, idx: upd_idx, val: upd_val};
        if (alloff_req)   win.cmd = CMD_ALLOFF;
        else if (off_req) win.cmd = CMD_OFF;
        else if (on_req)  win.cmd = CMD_ON;
    end
endmodule

// File: rtl/prs_shifter.sv
module prs_shifter
    import prs_pkg::*;
#(
    parameter int unsigned HALF_BIT = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  panel_ctl_t word,
    output logic       sclk_o,
    output logic       sdat_o,
    output logic       str_o,
    output logic       done_o
);
    localparam int unsigned HW = (HALF_BIT > 1) ? $clog2(HALF_BIT) : 1;
    localparam logic [HW-1:0] PH_LOAD = HW'(HALF_BIT - 1);

    sh_st_e        st;
    logic [7:0]    shreg;
    logic [2:0]    bit_i;
    logic [HW-1:0] ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SH_IDLE;
            shreg  <= '0;
            bit_i  <= '0;
            ph     <= '0;
            sclk_o <= 1'b0;
            sdat_o <= 1'b0;
            str_o  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (st)
                SH_IDLE: begin
                    if (start) begin
                        shreg  <= word;
                        bit_i  <= 3'd7;
                        str_o  <= 1'b0;
                        sclk_o <= 1'b0;
                        sdat_o <= word[7];
                        ph     <= PH_LOAD;
                        st     <= SH_LOW;
                    end
                end
                SH_LOW: begin
                    if (ph == '0) begin
                        sclk_o <= 1'b1;
                        ph     <= PH_LOAD;
                        st     <= SH_HIGH;
                    end else begin
                        ph <= ph - 1'b1;
                    end
                end
                SH_HIGH: begin
                    if (ph == '0) begin
                        if (bit_i == 3'd0) begin
                            str_o  <= 1'b1;
                            done_o <= 1'b1;
                            st     <= SH_IDLE;
                        end else begin
                            bit_i  <= bit_i - 3'd1;
                            sclk_o <= 1'b0;
                            sdat_o <= shreg[bit_i - 3'd1];
                            ph     <= PH_LOAD;
                            st     <= SH_LOW;
                        end
                    end else begin
                        ph <= ph - 1'b1;
                    end
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

    AST_SCLK_RISE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_o) |-> !str_o); // R3
    AST_DATA_HELD_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && $past(sclk_o)) |-> $stable(sdat_o)); // R3
    AST_STROBE_RISE_ENDS_SEND: assert property (@(posedge clk) disable iff (rst)
        $rose(str_o) |-> done_o); // R3
endmodule

// File: rtl/prs_timer.sv
module prs_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] cycles,
    output logic          expired
);
    logic          running;
    logic [CW-1:0] cnt;

    assign expired = running && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (load) begin
            running <= 1'b1;
            cnt     <= cycles - 1'b1;
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - 1'b1;
        end
    end

    AST_TMR_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        load |-> !running); // R5
    AST_TMR_NONZERO_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |-> (cycles != '0)); // R7
endmodule

// File: rtl/panel_rail_seq.sv
module panel_rail_seq
    import prs_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 240,
    parameter int unsigned HALF_BIT   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       on_req,
    input  logic       off_req,
    input  logic       alloff_req,
    input  logic       upd_req,
    input  logic [2:0] upd_idx,
    input  logic       upd_val,
    output logic       ser_clk_o,
    output logic       ser_dat_o,
    output logic       ser_str_o,
    output logic       src_start_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       queued_o,
    output logic       reject_o
);
    localparam int unsigned MAX_CYC = MAX_WAIT_US * CYC_PER_US;
    localparam int unsigned CW      = $clog2(MAX_CYC + 1);

    seq_st_e       state;
    req_t          cur;
    req_t          pend;
    logic          pend_v;
    logic [1:0]    step;
    panel_ctl_t    word;
    step_t         st_now;

    logic          any, multi;
    req_t          win;
    logic          idle, take_pend, start_new, queue_new;
    logic          sh_start, sh_done;
    logic          tmr_load, tmr_expired;
    logic [CW-1:0] tmr_cycles;

    prs_arbiter u_arb (
        .on_req     (on_req),
        .off_req    (off_req),
        .alloff_req (alloff_req),
        .upd_req    (upd_req),
        .upd_idx    (upd_idx),
        .upd_val    (upd_val),
        .any        (any),
        .multi      (multi),
        .win        (win)
    );

    assign st_now     = seq_step(cur.cmd, step, word, cur.idx, cur.val);
    assign idle       = (state == ST_IDLE);
    assign busy_o     = !idle;
    assign take_pend  = idle && pend_v;
    assign start_new  = idle && !pend_v && any;
    assign queue_new  = any && !start_new && (!pend_v || take_pend);
    assign sh_start   = (state == ST_LAUNCH);
    assign tmr_cycles = CW'(st_now.wait_us * CYC_PER_US);
    assign tmr_load   = (state == ST_SHIFT) && sh_done && !st_now.last
                        && (st_now.wait_us != '0);

    prs_shifter #(.HALF_BIT(HALF_BIT)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .start  (sh_start),
        .word   (st_now.word),
        .sclk_o (ser_clk_o),
        .sdat_o (ser_dat_o),
        .str_o  (ser_str_o),
        .done_o (sh_done)
    );

    prs_timer #(.CW(CW)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .cycles  (tmr_cycles),
        .expired (tmr_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_LAUNCH;
            cur         <= '{cmd: CMD_INIT, idx: 3'd0, val: 1'b0};
            pend        <= '{cmd: CMD_INIT, idx: 3'd0, val: 1'b0};
            pend_v      <= 1'b0;
            step        <= '0;
            word        <= CTL_RESET;
            src_start_o <= 1'b0;
            done_o      <= 1'b0;
            queued_o    <= 1'b0;
            reject_o    <= 1'b0;
        end else begin
            done_o   <= 1'b0;
            queued_o <= queue_new;
            reject_o <= any && ((!start_new && !queue_new) || multi);

            if (queue_new) begin
                pend_v <= 1'b1;
                pend   <= win;
            end else if (take_pend) begin
                pend_v <= 1'b0;
            end

            case (state)
                ST_IDLE: begin
                    if (take_pend) begin
                        cur   <= pend;
                        step  <= '0;
                        state <= ST_LAUNCH;
                    end else if (start_new) begin
                        cur   <= win;
                        step  <= '0;
                        state <= ST_LAUNCH;
                    end
                end
                ST_LAUNCH: begin
                    word  <= st_now.word;
                    state <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (sh_done) begin
                        if (st_now.last) begin
                            done_o <= 1'b1;
                            state  <= ST_IDLE;
                            if (st_now.src_hi) src_start_o <= 1'b1;
                            if (st_now.src_lo) src_start_o <= 1'b0;
                        end else begin
                            step  <= step + 2'd1;
                            state <= (st_now.wait_us == '0) ? ST_LAUNCH : ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (tmr_expired) state <= ST_LAUNCH;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o); // R10
    AST_STROBE_LOW_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        !ser_str_o |-> busy_o); // R10
    AST_SRC_RISE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(src_start_o) |-> done_o); // R9
    AST_QUEUE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        queued_o |-> $past(on_req || off_req || alloff_req || upd_req)); // R11
    AST_REJECT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        reject_o |-> $past(on_req || off_req || alloff_req || upd_req)); // R12
endmodule

// File: tb/tb_panel_rail_seq.sv
module tb_panel_rail_seq;
    localparam int unsigned C    = 2;
    localparam int unsigned HALF = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       on_req = 0, off_req = 0, alloff_req = 0, upd_req = 0;
    logic [2:0] upd_idx = '0;
    logic       upd_val = 1'b0;
    logic       ser_clk_o, ser_dat_o, ser_str_o, src_start_o;
    logic       busy_o, done_o, queued_o, reject_o;

    int checks = 0;
    int fails  = 0;

    panel_rail_seq #(.CYC_PER_US(C), .HALF_BIT(HALF)) dut (
        .clk(clk), .rst(rst), .on_req(on_req), .off_req(off_req),
        .alloff_req(alloff_req), .upd_req(upd_req), .upd_idx(upd_idx),
        .upd_val(upd_val), .ser_clk_o(ser_clk_o), .ser_dat_o(ser_dat_o),
        .ser_str_o(ser_str_o), .src_start_o(src_start_o), .busy_o(busy_o),
        .done_o(done_o), .queued_o(queued_o), .reject_o(reject_o)
    );

    always #4 clk = ~clk;

    // Model of the external latch plus strobe timing log.
    logic [7:0] words  [64];
    int         nbits  [64];
    logic       firsts [64];
    int         gaps   [64];
    int nw = 0, ng = 0, cyc = 0, rise_cyc = 0, bitcnt = 0;
    logic [7:0] cap = '0;
    logic first_bit = 1'b0, prev_sclk = 1'b0, prev_str = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (!prev_sclk && ser_clk_o) begin
            if (bitcnt == 0) first_bit = ser_dat_o;
            cap = {cap[6:0], ser_dat_o};
            bitcnt++;
        end
        if (!prev_str && ser_str_o && nw < 64) begin
            words[nw]  = cap;
            nbits[nw]  = bitcnt;
            firsts[nw] = first_bit;
            nw++;
            bitcnt   = 0;
            rise_cyc = cyc;
        end
        if (prev_str && !ser_str_o && ng < 64) begin
            gaps[ng] = cyc - rise_cyc;
            ng++;
        end
        prev_sclk = ser_clk_o;
        prev_str  = ser_str_o;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    logic q_seen, r_seen;

    task automatic pulse(input logic a_on, input logic a_off, input logic a_all,
                         input logic a_upd, input logic [2:0] i, input logic v);
        @(negedge clk);
        on_req = a_on; off_req = a_off; alloff_req = a_all; upd_req = a_upd;
        upd_idx = i; upd_val = v;
        @(negedge clk);
        q_seen = queued_o;
        r_seen = reject_o;
        on_req = 0; off_req = 0; alloff_req = 0; upd_req = 0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        @(negedge clk);
        while (!done_o && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(tag, int'(done_o), 1);
    endtask

    // {index, value, expected word}
    localparam logic [11:0] UPD_VEC [6] = '{
        {3'd6, 1'b1, 8'h72},
        {3'd0, 1'b1, 8'h73},
        {3'd0, 1'b0, 8'h72},
        {3'd7, 1'b1, 8'hF2},
        {3'd6, 1'b0, 8'hB2},
        {3'd7, 1'b0, 8'h32}
    };

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int base;
        // R1 / R10: state while reset is held
        repeat (3) @(negedge clk);
        chk("R1 strobe in reset", int'(ser_str_o), 0);
        chk("R1 sclk in reset", int'(ser_clk_o), 0);
        chk("R1 src in reset", int'(src_start_o), 0);
        chk("R10 busy in reset", int'(busy_o), 1);
        rst = 1'b0;
        wait_done("R10 init done");
        chk("R1 one init send", nw, 1);
        chk("R1 init word", int'(words[0]), 'h32);
        chk("R3 bits per send", nbits[0], 8);
        chk("R10 idle after done", int'(busy_o), 0);

        // R2: field update vectors
        for (int k = 0; k < 6; k++) begin
            base = nw;
            pulse(0, 0, 0, 1, UPD_VEC[k][11:9], UPD_VEC[k][8]);
            wait_done("R2 update done");
            chk("R2 one send per update", nw - base, 1);
            chk("R2 updated word", int'(words[nw-1]), int'(UPD_VEC[k][7:0]));
            if (k == 3) chk("R3 msb first", int'(firsts[nw-1]), 1);
        end

        // R4 / R5 / R9: power-up
        base = nw;
        pulse(1, 0, 0, 0, 3'd0, 1'b0);
        wait_done("R10 power-up done");
        chk("R4 send count", nw - base, 4);
        chk("R4 word 1", int'(words[base]),   'h30);
        chk("R4 word 2", int'(words[base+1]), 'h38);
        chk("R4 word 3", int'(words[base+2]), 'h3C);
        chk("R4 word 4", int'(words[base+3]), 'h3C);
        chk("R5 gap 1", gaps[base],   100*C + 2);
        chk("R5 gap 2", gaps[base+1], 500*C + 2);
        chk("R5 gap 3", gaps[base+2], 100*C + 2);
        chk("R9 src high after power-up", int'(src_start_o), 1);

        // R6 / R7 / R9: power-down
        base = nw;
        pulse(0, 1, 0, 0, 3'd0, 1'b0);
        wait_done("R10 power-down done");
        chk("R6 send count", nw - base, 4);
        chk("R6 word 1", int'(words[base]),   'h38);
        chk("R6 word 2", int'(words[base+1]), 'h30);
        chk("R6 word 3", int'(words[base+2]), 'h32);
        chk("R6 word 4", int'(words[base+3]), 'h22);
        chk("R7 gap 1", gaps[base],   10*C + 2);
        chk("R7 gap 2", gaps[base+1], 100*C + 2);
        chk("R7 gap 3", gaps[base+2], 2);
        chk("R9 src low after power-down", int'(src_start_o), 0);

        // R11 / R12: queue and reject while busy
        base = nw;
        pulse(1, 0, 0, 0, 3'd0, 1'b0);
        chk("R11 idle start not queued", int'(q_seen), 0);
        pulse(0, 1, 0, 0, 3'd0, 1'b0);
        chk("R11 queued pulse", int'(q_seen), 1);
        chk("R12 no reject when slot free", int'(r_seen), 0);
        pulse(0, 0, 0, 1, 3'd6, 1'b1);
        chk("R12 reject when slot full", int'(r_seen), 1);
        chk("R12 not queued when full", int'(q_seen), 0);
        wait_done("R11 first command done");
        wait_done("R11 queued command done");
        chk("R11 both commands ran", nw - base, 8);
        chk("R12 rejected update absent", int'(words[nw-1]), 'h22);

        // R8: all-off from powered state
        pulse(1, 0, 0, 0, 3'd0, 1'b0);
        wait_done("R10 power-up done");
        chk("R9 src high", int'(src_start_o), 1);
        base = nw;
        pulse(0, 0, 1, 0, 3'd0, 1'b0);
        wait_done("R8 all-off done");
        chk("R8 single send", nw - base, 1);
        chk("R8 zero word", int'(words[nw-1]), 0);
        chk("R8 src low", int'(src_start_o), 0);

        // R12: same-cycle arbitration, power-on beats update
        base = nw;
        pulse(1, 0, 0, 1, 3'd0, 1'b1);
        chk("R12 loser rejected", int'(r_seen), 1);
        chk("R12 loser not queued", int'(q_seen), 0);
        wait_done("R12 winner done");
        chk("R12 winner only", nw - base, 4);
        chk("R12 power-on from zero", int'(words[nw-1]), 'h3C);

        // R11: all-off queued behind power-down
        base = nw;
        pulse(0, 1, 0, 0, 3'd0, 1'b0);
        pulse(0, 0, 1, 0, 3'd0, 1'b0);
        chk("R11 all-off queued", int'(q_seen), 1);
        wait_done("R11 power-down done");
        wait_done("R11 queued all-off done");
        chk("R11 sends", nw - base, 5);
        chk("R11 final zero word", int'(words[nw-1]), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule